// File: doc/BRIEF.md
# Byte-Streaming SPI Master with Runtime Mode Selection

This block moves one byte at a time over a four-wire serial link as the master. Software uses a 16-bit configuration register to select the serial clock rate, the bit order, the polarity of chip select and of the serial clock, and the point at which incoming data is sampled. A write to the data register starts an 8-bit exchange. When the exchange finishes, the received byte can be read from the data register and, if enabled, an interrupt pulses for one cycle.

Two features suit command/response traffic. In stream mode, chip select stays asserted across several byte exchanges until software clears the stream bit. A routing bit sends the whole link to an internal on-chip slave instead of the external pins. The pin set that is not selected stays at its idle levels.

Top module: `spi_stream_master`

## Requirements
- R1: After reset the configuration reads 0x0002 and busy and irq are low. On both pin sets chip select is high and SCK is low.
- R2: A configuration write stores all 16 bits, and they read back unchanged. Bits 7:0 are the prescaler, bit 8 is LSB-first, bit 9 sets chip select active high, bit 10 sets SCK idle high, bit 11 samples on the same edge, bit 12 is stream, bit 13 is enable, bit 14 is interrupt enable and bit 15 routes the link to the internal pins.
- R3: A data write while enabled and idle raises busy on the next edge. Busy stays high for exactly 16 × prescaler clock cycles.
- R4: SCK rests at the bit-10 level and gives exactly 8 pulses per byte. Each half-period is one prescaler span.
- R5: MOSI carries bit 7 first when bit 8 is 0, and bit 0 first when bit 8 is 1. Each bit is valid at the SCK leading edge and changes only on the trailing edge.
- R6: With bit 11 at 0, MISO is sampled on each leading edge. With bit 11 at 1 it is sampled on each trailing edge. The first bit received lands in bit 7 for MSB-first order and in bit 0 for LSB-first order.
- R7: At completion, busy falls, the received byte appears on the data read port, and irq is high for exactly one cycle if bit 14 is set.
- R8: With bit 12 set, chip select stays asserted after each byte. It is released one cycle after a configuration write clears bit 12. Without bit 12, chip select is released in the cycle in which busy falls.
- R9: A data write is ignored while enable is 0 or while busy is high. Such a write starts no SCK activity and does not alter the byte in flight or the one already received.
- R10: Bit 15 selects which pin set carries the link and which MISO input is sampled. The other set holds SCK at its idle level, chip select inactive and MOSI at 0.
- R11: While a byte is in flight, chip select is at the level bit 9 gives (high when bit 9 is 1, low when it is 0). When inactive, it is at the opposite level.
- R12: A prescaler of 0 behaves as a prescaler of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write value |
| cfg_rdata_o | output | 16 | Configuration read value |
| data_we_i | input | 1 | Data write strobe, starts a byte |
| data_wdata_i | input | 8 | Byte to transmit |
| data_rdata_o | output | 8 | Last received byte |
| busy_o | output | 1 | Byte exchange in progress |
| irq_o | output | 1 | One-cycle completion pulse |
| sck_ext_o | output | 1 | External serial clock |
| cs_ext_o | output | 1 | External chip select |
| mosi_ext_o | output | 1 | External serial data out |
| miso_ext_i | input | 1 | External serial data in |
| sck_int_o | output | 1 | Internal serial clock |
| cs_int_o | output | 1 | Internal chip select |
| mosi_int_o | output | 1 | Internal serial data out |
| miso_int_i | input | 1 | Internal serial data in |

## Verification
The assertions assume that software leaves the prescaler, edge, order and routing fields unchanged while busy is high. Only the stream bit may change mid-byte. The half-period counter bound and the SCK phase relations depend on this. The stimulus writes the configuration only between bytes, except for clearing stream after the last byte of a burst. The bench slave changes MISO one half-cycle after each SCK leading edge, so leading-edge and trailing-edge sampling give different, predictable bytes.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;
  localparam int PRESC_W = 8;

  typedef struct packed {
    logic               int_route;
    logic               irq_en;
    logic               enable;
    logic               stream;
    logic               same_edge;
    logic               sck_inv;
    logic               cs_high;
    logic               lsb_first;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam logic [CFG_W-1:0] CFG_RST = {{(CFG_W-PRESC_W){1'b0}}, PRESC_W'(2)};
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o = run_i && (cnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i || !run_i || tick_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + DIV_W'(1);
  end

  // R12: counter never passes the effective divisor
  a_r12_cnt_below_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < lim);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              lsb_first_i,
  input  logic              same_edge_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_ph_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_nxt_o
);
  localparam int HALF_N = 2 * DATA_W;
  localparam int HW     = $clog2(HALF_N);

  logic [HW-1:0]     h_q;
  logic              busy_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              last, lead_tick, trail_tick, sample;

  assign last       = (h_q == HW'(HALF_N - 1));
  assign lead_tick  = busy_q && tick_i && !h_q[0];
  assign trail_tick = busy_q && tick_i && h_q[0];
  assign sample     = same_edge_i ? trail_tick : lead_tick;
  assign rx_nxt_o   = !sample ? rx_q :
                      lsb_first_i ? {miso_i, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso_i};
  assign done_o     = trail_tick && last;
  assign busy_o     = busy_q;
  assign sck_ph_o   = h_q[0];
  assign mosi_o     = lsb_first_i ? tx_q[0] : tx_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0; busy_q <= 1'b0; tx_q <= '0; rx_q <= '0;
    end else if (start_i) begin
      h_q <= '0; busy_q <= 1'b1; tx_q <= tx_i; rx_q <= '0;
    end else if (busy_q && tick_i) begin
      h_q  <= last ? '0 : h_q + HW'(1);
      rx_q <= rx_nxt_o;
      if (trail_tick && !last)
        tx_q <= lsb_first_i ? (tx_q >> 1) : (tx_q << 1);
      if (last) busy_q <= 1'b0;
    end
  end

  // R4: SCK phase rests at idle whenever no byte is in flight
  a_r4_idle_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> h_q == '0);
  // R3: a start always produces a busy byte
  a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
  import spi_stream_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sck_ext_o,
  output logic              cs_ext_o,
  output logic              mosi_ext_o,
  input  logic              miso_ext_i,
  output logic              sck_int_o,
  output logic              cs_int_o,
  output logic              mosi_int_o,
  input  logic              miso_int_i
);
  cfg_t              cfg_q;
  logic              start, tick, busy, done, sck_ph, mosi, miso;
  logic [DATA_W-1:0] rx_nxt, rdata_q;
  logic              cs_act_q, irq_q;
  logic              sck_lvl, cs_lvl, sck_idle, cs_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= cfg_t'(CFG_RST);
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign start = data_we_i && cfg_q.enable && !busy;
  assign miso  = cfg_q.int_route ? miso_int_i : miso_ext_i;

  spi_half_tick #(.DIV_W(PRESC_W)) u_tick (
    .clk_i, .rst_ni,
    .run_i   (busy),
    .clear_i (start),
    .div_i   (cfg_q.presc),
    .tick_o  (tick)
  );

  spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i     (start),
    .tx_i        (data_wdata_i),
    .lsb_first_i (cfg_q.lsb_first),
    .same_edge_i (cfg_q.same_edge),
    .tick_i      (tick),
    .miso_i      (miso),
    .busy_o      (busy),
    .done_o      (done),
    .sck_ph_o    (sck_ph),
    .mosi_o      (mosi),
    .rx_nxt_o    (rx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_act_q <= 1'b0; rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      if (start)                            cs_act_q <= 1'b1;
      else if ((!busy || done) && !cfg_q.stream) cs_act_q <= 1'b0;
      if (done) rdata_q <= rx_nxt;
      irq_q <= done && cfg_q.irq_en;
    end
  end

  assign sck_idle = cfg_q.sck_inv;
  assign cs_idle  = ~cfg_q.cs_high;
  assign sck_lvl  = cfg_q.sck_inv ^ sck_ph;
  assign cs_lvl   = cs_act_q ? cfg_q.cs_high : cs_idle;

  // routed pin set carries the link, the other rests idle
  assign sck_ext_o  = cfg_q.int_route ? sck_idle : sck_lvl;
  assign cs_ext_o   = cfg_q.int_route ? cs_idle  : cs_lvl;
  assign mosi_ext_o = cfg_q.int_route ? 1'b0     : mosi;
  assign sck_int_o  = cfg_q.int_route ? sck_lvl  : sck_idle;
  assign cs_int_o   = cfg_q.int_route ? cs_lvl   : cs_idle;
  assign mosi_int_o = cfg_q.int_route ? mosi     : 1'b0;

  assign cfg_rdata_o  = cfg_q;
  assign data_rdata_o = rdata_q;
  assign busy_o       = busy;
  assign irq_o        = irq_q;

  // R8: chip select covers every byte in flight
  a_r8_cs_covers_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> cs_act_q);
  // R7: interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R7: interrupt coincides with the fall of busy
  a_r7_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> !busy && $past(busy));
  // R9: a disabled idle master stays idle
  a_r9_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.enable && !busy && !cfg_we_i) |=> !busy);
endmodule

// File: tb/tb_spi_stream_master.sv
module tb_spi_stream_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        data_we_i = 1'b0;
  logic [7:0]  data_wdata_i = '0;
  logic [7:0]  data_rdata_o;
  logic        busy_o, irq_o;
  logic        sck_ext_o, cs_ext_o, mosi_ext_o;
  logic        sck_int_o, cs_int_o, mosi_int_o;
  logic        miso_ext_i = 1'b0;
  logic        miso_int_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] cur;

  always #10 clk_i = ~clk_i;

  spi_stream_master dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk_i); cfg_wdata_i = v; cfg_we_i = 1'b1;
    @(negedge clk_i); cfg_we_i = 1'b0;
    cur = v;
    chk(cfg_rdata_o == v, "R2", cfg_rdata_o, v);
  endtask

  task automatic drive_miso(input bit rt, input bit b);
    if (rt) begin miso_int_i = b; miso_ext_i = ~b; end
    else    begin miso_ext_i = b; miso_int_i = ~b; end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rxp, input bit poke,
                      input bit cs_after);
    int  div, cyc, lead;
    bit  lsb, csh, inv, same, ien, rt, prev, sck_now, cs_ok, oth_ok;
    logic [8:0] s;
    logic [7:0] cap, exp_mosi, exp_rx, rd_before;
    lsb = cur[8]; csh = cur[9]; inv = cur[10]; same = cur[11]; ien = cur[14]; rt = cur[15];
    div = (cur[7:0] == 0) ? 1 : int'(cur[7:0]);
    for (int j = 0; j < 8; j++) s[j] = rxp[7-j];
    s[8] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      exp_mosi[k] = lsb ? tx[k] : tx[7-k];
      if (lsb) exp_rx[k]   = same ? s[k+1] : s[k];
      else     exp_rx[7-k] = same ? s[k+1] : s[k];
    end
    rd_before = data_rdata_o;
    @(negedge clk_i);
    data_wdata_i = tx; data_we_i = 1'b1;
    drive_miso(rt, s[0]);
    lead = 0; cyc = 0; cap = '0; prev = inv; cs_ok = 1; oth_ok = 1;
    forever begin
      @(negedge clk_i);
      data_we_i = poke && (cyc == 3);
      if (data_we_i) data_wdata_i = ~tx;
      if (!busy_o || cyc > 1000) break;
      cyc++;
      sck_now = rt ? sck_int_o : sck_ext_o;
      if ((rt ? cs_int_o : cs_ext_o) != csh) cs_ok = 0;
      if (rt ? !(sck_ext_o == inv && cs_ext_o == !csh && mosi_ext_o == 1'b0)
             : !(sck_int_o == inv && cs_int_o == !csh && mosi_int_o == 1'b0)) oth_ok = 0;
      if (sck_now != inv && prev == inv) begin
        if (lead < 8) cap[lead] = rt ? mosi_int_o : mosi_ext_o;
        lead++;
        drive_miso(rt, s[(lead < 8) ? lead : 8]);
      end
      prev = sck_now;
    end
    data_we_i = 1'b0;
    chk(cyc == 16 * div, (cur[7:0] == 0) ? "R12" : "R3", cyc, 16 * div);
    chk(lead == 8, "R4", lead, 8);
    chk((rt ? sck_int_o : sck_ext_o) == inv, "R4", rt ? sck_int_o : sck_ext_o, inv);
    chk(cap == exp_mosi, "R5", cap, exp_mosi);
    chk(data_rdata_o == exp_rx, poke ? "R9" : "R6", data_rdata_o, exp_rx);
    chk(irq_o == ien, "R7", irq_o, ien);
    chk(cs_ok, "R11", cs_ok, 1);
    chk(oth_ok, "R10", oth_ok, 1);
    chk((rt ? cs_int_o : cs_ext_o) == (cs_after ? csh : !csh), "R8",
        rt ? cs_int_o : cs_ext_o, cs_after ? csh : !csh);
    if (rd_before == exp_rx) chk(1'b1, "R6", 0, 0);
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R7", irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    cur = 16'h0002;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cfg_rdata_o == 16'h0002, "R1", cfg_rdata_o, 16'h0002);
    chk(!busy_o && !irq_o, "R1", {busy_o, irq_o}, 0);
    chk(cs_ext_o && cs_int_o, "R1", {cs_ext_o, cs_int_o}, 3);
    chk(!sck_ext_o && !sck_int_o, "R1", {sck_ext_o, sck_int_o}, 0);

    write_cfg(16'hA5C3);
    write_cfg(16'h5A3C);

    // near-exhaustive sweep of prescaler and mode bits
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        logic [15:0] c;
        c = {m[3], m[1] ^ p[1], 1'b1, 1'b0, m[1], m[2], p[0] ^ m[0], m[0], 8'(p)};
        write_cfg(c);
        xfer(8'(8'h3C + p * 37 + m * 11), 8'(8'hA6 ^ (m * 29)), m[2] & p[0], 1'b0);
      end
    end

    // R8 stream mode holds chip select across bytes
    write_cfg(16'h7002);
    xfer(8'h81, 8'h5E, 1'b0, 1'b1);
    xfer(8'h7E, 8'hC3, 1'b0, 1'b1);
    write_cfg(16'h2002);
    @(negedge clk_i);
    chk(cs_ext_o == 1'b1, "R8", cs_ext_o, 1);
    write_cfg(16'hB302);
    xfer(8'h96, 8'h2D, 1'b0, 1'b1);
    write_cfg(16'h2302);
    @(negedge clk_i);
    chk(cs_int_o == 1'b0, "R8", cs_int_o, 0);

    // R9 data write with enable cleared
    write_cfg(16'h0002);
    keep = data_rdata_o;
    @(negedge clk_i); data_wdata_i = 8'hFF; data_we_i = 1'b1;
    @(negedge clk_i); data_we_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (busy_o || sck_ext_o || !cs_ext_o) begin
        chk(1'b0, "R9", {busy_o, sck_ext_o, cs_ext_o}, 1);
        break;
      end
    end
    chk(!busy_o, "R9", busy_o, 0);
    chk(data_rdata_o == keep, "R9", data_rdata_o, keep);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule